// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block breaks a multi-register load or store into single-word transfers. When idle it accepts a start request carrying a base address, a 16-bit register-select mask, a stepping mode and a writeback flag. It then issues one transfer per selected register on a valid/ready output stream. Each beat carries a register index and a word address. The register file and memory accesses are done by the logic that consumes the stream.

The selected registers always cover one contiguous range of words. In all four modes the lowest-numbered register lands at the lowest address. For the decrement modes the block precomputes the bottom of the range from the number of set mask bits, so it can always issue registers in ascending order. At the end it pulses a done flag, and if writeback was requested it presents the updated base value alongside that pulse.

The transfer stream follows valid/ready rules for back-pressure. A beat is taken on any rising edge where valid and ready are both high. While ready is low the beat is held unchanged. Valid never depends on ready. Start, mode, flag and done stay plain level or pulse pins.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o, xfer_valid_o, done_o and wb_valid_o are all low.
- R2: Each set bit of the mask produces exactly one beat, whose xfer_reg_o is that bit's position (0..15). Beats go out in ascending register order, and no beat is issued for a clear bit.
- R3: Each beat's address is 4 above the previous beat's address, so the lowest register gets the lowest address of one contiguous word range.
- R4: Mode code 0 (step up, after) gives the first beat the base address unchanged.
- R5: Mode code 1 (step up, before) gives the first beat base + 4.
- R6: Mode code 2 (step down, after) gives the first beat base − 4·N + 4, where N is the number of set mask bits.
- R7: Mode code 3 (step down, before) gives the first beat base − 4·N.
- R8: The first beat is valid in the cycle after the start edge. A beat held with ready low keeps its index and address unchanged. With ready high, a new beat (or done) follows in the very next cycle.
- R9: done_o is a one-cycle pulse in the cycle after the final handshake, with xfer_valid_o low. An empty mask gives done_o in the cycle after the start edge and no beats.
- R10: wb_valid_o is high together with done_o exactly when the writeback flag was set at start. wb_addr_o then equals base + 4·N for modes 0 and 1, and base − 4·N for modes 2 and 3, modulo 2^32.
- R11: A start request is ignored while busy_o is high, which covers the done cycle. The running sequence is unchanged and the block is idle one cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| mode_i | input | 2 | Stepping mode: 0 up-after, 1 up-before, 2 down-after, 3 down-before |
| base_i | input | 32 | Base byte address |
| mask_i | input | 16 | Register-select mask, bit n selects register n |
| wb_en_i | input | 1 | Request the updated base value at the end |
| busy_o | output | 1 | A sequence is running (beats or done cycle) |
| xfer_valid_o | output | 1 | Transfer beat valid |
| xfer_ready_i | input | 1 | Consumer accepts the beat |
| xfer_reg_o | output | 4 | Register index of the beat |
| xfer_addr_o | output | 32 | Word address of the beat |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wb_valid_o | output | 1 | Writeback value valid (with done_o) |
| wb_addr_o | output | 32 | Updated base value |

## Verification
Every result is registered and appears one cycle after the edge that causes it. The first beat, or done for an empty mask, is due one cycle after the start edge. After a handshake, the next beat or done is due one cycle later. The idle state is due one cycle after done. The bench drives inputs and samples outputs at the falling edge. It decides at each falling edge whether the coming rising edge is a handshake, and it checks the following falling edge against exactly that one-cycle expectation. Garbage start requests are held during each run, so any restart would show up as a wrong beat.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    STEP_UP_AFTER  = 2'd0,
    STEP_UP_BEFORE = 2'd1,
    STEP_DN_AFTER  = 2'd2,
    STEP_DN_BEFORE = 2'd3
  } step_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/blkx_lsb_pick.sv
module blkx_lsb_pick #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o    = IW'(i);
        onehot_o = W'(1) << i;
      end
    end
  end
endmodule

// File: rtl/blkx_addr_plan.sv
module blkx_addr_plan
  import blkx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(NREG + 1),
  localparam int SH = $clog2(WORD_BYTES)
) (
  input  logic [AW-1:0] base_i,
  input  step_mode_e    mode_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] wb_o
);
  logic [AW-1:0] span;
  logic [AW-1:0] step;
  logic [AW-1:0] low_end;
  logic [AW-1:0] high_end;

  assign span     = AW'(cnt_i) << SH;
  assign step     = AW'(WORD_BYTES);
  assign low_end  = base_i - span;
  assign high_end = base_i + span;

  always_comb begin
    unique case (mode_i)
      STEP_UP_AFTER:  first_o = base_i;
      STEP_UP_BEFORE: first_o = base_i + step;
      STEP_DN_AFTER:  first_o = low_end + step;
      default:        first_o = low_end;
    endcase
    wb_o = mode_i[1] ? low_end : high_end;
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int CW    = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [AW-1:0]    base_i,
  input  logic [NREG-1:0]  mask_i,
  input  logic             wb_en_i,
  output logic             busy_o,
  output logic             xfer_valid_o,
  input  logic             xfer_ready_i,
  output logic [IDX_W-1:0] xfer_reg_o,
  output logic [AW-1:0]    xfer_addr_o,
  output logic             done_o,
  output logic             wb_valid_o,
  output logic [AW-1:0]    wb_addr_o
);
  seq_state_e      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   wb_q;
  logic            wb_en_q;

  logic [CW-1:0]   sel_cnt;
  logic [AW-1:0]   plan_first;
  logic [AW-1:0]   plan_wb;
  logic [IDX_W-1:0] pick_idx;
  logic [NREG-1:0] pick_oh;
  logic [NREG-1:0] rem_next;
  logic            accept;
  logic            beat;

  blkx_popcnt #(.W(NREG)) u_cnt (
    .vec_i (mask_i),
    .cnt_o (sel_cnt)
  );

  blkx_addr_plan #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base_i  (base_i),
    .mode_i  (step_mode_e'(mode_i)),
    .cnt_i   (sel_cnt),
    .first_o (plan_first),
    .wb_o    (plan_wb)
  );

  blkx_lsb_pick #(.W(NREG)) u_pick (
    .vec_i    (rem_q),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  assign accept   = (state_q == SEQ_IDLE) && start_i;
  assign beat     = (state_q == SEQ_RUN) && xfer_ready_i;
  assign rem_next = rem_q & ~pick_oh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      wb_en_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            rem_q   <= mask_i;
            addr_q  <= plan_first;
            wb_q    <= plan_wb;
            wb_en_q <= wb_en_i;
            state_q <= (mask_i == '0) ? SEQ_FIN : SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (beat) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + AW'(WORD_BYTES);
            if (rem_next == '0) state_q <= SEQ_FIN;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != SEQ_IDLE);
  assign xfer_valid_o = (state_q == SEQ_RUN);
  assign xfer_reg_o   = pick_idx;
  assign xfer_addr_o  = addr_q;
  assign done_o       = (state_q == SEQ_FIN);
  assign wb_valid_o   = (state_q == SEQ_FIN) && wb_en_q;
  assign wb_addr_o    = wb_q;
endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 4,
  parameter int WB    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             xfer_valid_o,
  input logic             xfer_ready_i,
  input logic [IDX_W-1:0] xfer_reg_o,
  input logic [AW-1:0]    xfer_addr_o,
  input logic             done_o,
  input logic             wb_valid_o
);
  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_ready_i) |=>
      (done_o || (xfer_valid_o && xfer_addr_o == $past(xfer_addr_o) + AW'(WB))));

  // R2
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_ready_i) |=> (done_o || (xfer_reg_o > $past(xfer_reg_o))));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!xfer_valid_o && busy_o));

  // R10
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o);

  // R11
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

bind blk_xfer_seq blkx_seq_chk #(.AW(AW), .IDX_W(IDX_W), .WB(WORD_BYTES)) i_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_reg_o   (xfer_reg_o),
  .xfer_addr_o  (xfer_addr_o),
  .done_o       (done_o),
  .wb_valid_o   (wb_valid_o)
);

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic        wb_en_i = 1'b0;
  logic        busy_o, xfer_valid_o, done_o, wb_valid_o;
  logic        xfer_ready_i = 1'b0;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o, wb_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_i(base_i), .mask_i(mask_i), .wb_en_i(wb_en_i), .busy_o(busy_o),
    .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o), .done_o(done_o),
    .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] md);
    case (md)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_seq(input logic [1:0] md, input logic [31:0] base,
                         input logic [15:0] mask, input logic wb, input logic [7:0] pat);
    int n = $countones(mask);
    logic [31:0] lo;
    logic [31:0] wbx;
    logic [15:0] rem = mask;
    int k = 0;
    int guard = 0;
    bit fin = 0;
    bit prev_hs = 0;
    bit prev_v = 0;
    logic [31:0] prev_addr = '0;
    logic [3:0] prev_reg = '0;
    int exp_idx;
    bit rdy;
    case (md)
      2'd0: lo = base;
      2'd1: lo = base + 32'd4;
      2'd2: lo = base - 32'(4 * n) + 32'd4;
      default: lo = base - 32'(4 * n);
    endcase
    wbx = md[1] ? base - 32'(4 * n) : base + 32'(4 * n);

    @(negedge clk);
    start_i = 1'b1; mode_i = md; base_i = base; mask_i = mask; wb_en_i = wb;
    xfer_ready_i = 1'b0;
    @(negedge clk);
    while (!fin && guard < 120) begin
      // garbage start requests during the run: must be ignored (R11)
      start_i = pat[guard % 8]; mask_i = ~mask; base_i = ~base; mode_i = ~md; wb_en_i = ~wb;
      if (guard == 0) begin
        if (mask == 0)
          check(done_o && !xfer_valid_o, "R9", "empty mask done after start", {30'd0, done_o, xfer_valid_o}, 32'd2);
        else
          check(xfer_valid_o && !done_o, "R8", "first beat after start", {30'd0, done_o, xfer_valid_o}, 32'd1);
      end
      if (prev_hs) begin
        if (rem == 0)
          check(done_o && !xfer_valid_o, "R9", "done after last beat", {30'd0, done_o, xfer_valid_o}, 32'd2);
        else
          check(xfer_valid_o && !done_o, "R8", "next beat follows", {30'd0, done_o, xfer_valid_o}, 32'd1);
      end
      if (prev_v && !prev_hs) begin
        check(xfer_valid_o, "R8", "valid held", {31'd0, xfer_valid_o}, 32'd1);
        check(xfer_addr_o == prev_addr && xfer_reg_o == prev_reg, "R8", "beat held stable",
              xfer_addr_o, prev_addr);
      end
      rdy = pat[(guard + 3) % 8] | (guard > 40);
      xfer_ready_i = rdy;
      prev_v = xfer_valid_o;
      prev_addr = xfer_addr_o;
      prev_reg = xfer_reg_o;
      prev_hs = xfer_valid_o && rdy;
      if (xfer_valid_o && rdy) begin
        exp_idx = 16;
        for (int b = 15; b >= 0; b--) if (rem[b]) exp_idx = b;
        check(32'(xfer_reg_o) == 32'(exp_idx), "R2", "register index", 32'(xfer_reg_o), 32'(exp_idx));
        if (k == 0)
          check(xfer_addr_o == lo, mode_req(md), "first address", xfer_addr_o, lo);
        else
          check(xfer_addr_o == lo + 32'(4 * k), "R3", "contiguous address", xfer_addr_o, lo + 32'(4 * k));
        if (exp_idx < 16) rem[exp_idx] = 1'b0;
        k++;
      end
      if (done_o) begin
        check(k == n && rem == 0, "R2", "beat count", 32'(k), 32'(n));
        check(wb_valid_o == wb, "R10", "writeback valid", {31'd0, wb_valid_o}, {31'd0, wb});
        if (wb) check(wb_addr_o == wbx, "R10", "writeback value", wb_addr_o, wbx);
        fin = 1;
      end
      guard++;
      @(negedge clk);
    end
    if (!fin) check(1'b0, "R9", "done never seen", 32'(guard), 32'd0);
    check(!busy_o && !xfer_valid_o && !done_o, "R11", "idle after done",
          {29'd0, busy_o, xfer_valid_o, done_o}, 32'd0);
    start_i = 1'b0;
    xfer_ready_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] m;
    logic [7:0] pats [4] = '{8'hFF, 8'hA5, 8'h3C, 8'h91};
    #1;
    check(!busy_o && !xfer_valid_o && !done_o && !wb_valid_o, "R1", "reset outputs",
          {28'd0, busy_o, xfer_valid_o, done_o, wb_valid_o}, 32'd0);
    repeat (3) @(negedge clk);
    check(!busy_o && !xfer_valid_o && !done_o && !wb_valid_o, "R1", "outputs held in reset",
          {28'd0, busy_o, xfer_valid_o, done_o, wb_valid_o}, 32'd0);
    rst_n = 1'b1;
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 84; i++) begin
        case (i)
          0: m = 16'h0000;
          1: m = 16'hFFFF;
          2: m = 16'h0001;
          3: m = 16'h8000;
          default: m = 16'(i * 16'h9E37) ^ 16'(i << 5);
        endcase
        run_seq(2'(md), (i == 5) ? 32'd0 : 32'h0000_4000 + 32'(i * 20) + 32'(md << 12),
                m, i[0], pats[i % 4]);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule